// File: doc/BRIEF.md
# Strided Vector Load/Store Sequencer

This block turns one vector memory instruction into a stream of scalar memory requests, one element per accepted handshake. The issuing stage presents the base register number and its value, an immediate, the first data register, the vector length, a segment count and an element-size code. The block answers with a new address and register index per element. The memory and the register file stay outside. The consumer accepts an element by holding `req_ready` high.

Two offset slots are programmed by a setup write. Each slot holds a register number, a bank bit, a mode bit and an offset amount. A command whose base register and bank match a valid slot adds that slot's amount to the start address. The slot's mode bit then picks the step: the command's immediate, or the element size. Segmented access interleaves several register groups per element. When the registers needed would run past the last register, the command is refused and an error pulse is returned.

Top module: `vec_stride_seq`

## Requirements
- R1: A setup write (`cfg_valid`) stores register number, bank, mode and amount into slot `cfg_slot`. It affects only commands accepted in later cycles. A command accepted in the same cycle as the write uses the slot contents from before the write.
- R2: A slot applies when it has been written and its register number and bank bit both equal the command's base register and bank. When both slots apply, slot 0 wins.
- R3: With an applying slot whose mode bit is 1 (offset mode), the start address is base value plus slot amount. The step is the immediate taken as a two's-complement value. All address arithmetic wraps modulo 2^32.
- R4: With no applying slot, or an applying slot whose mode bit is 0, the step is the element size in bytes: code 0/1/2/3 gives 1/2/4/8. An applying unit-mode slot still adds its amount to the start.
- R5: Without segments (`cmd_seg`=0), element i goes to register N+i and address start + i*step.
- R6: With `cmd_seg`=S, requests run element-major with the field index j innermost. The request for element i, field j carries address start + (i*(S+1)+j)*step and register N + j*VL + i.
- R7: A command produces exactly VL*(S+1) requests. VL=0 produces none and still gives a done pulse. `cmd_ready` is high only while idle.
- R8: One request is accepted per cycle while `req_ready` is high. While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_reg` hold.
- R9: `done` is high for exactly one cycle, in the cycle after the last request is accepted. `cmd_ready` is high in the following cycle.
- R10: If N + VL*(S+1) - 1 exceeds 31, the command issues no request. Instead `err` is high for one cycle, in the cycle after acceptance, with no done pulse.
- R11: `req_store` and `req_fbank` carry the accepted command's store and bank bits for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Setup write strobe |
| cfg_slot | input | 1 | Slot selected by the setup write |
| cfg_reg | input | 5 | Register number to match |
| cfg_fbank | input | 1 | Bank to match (1 = float) |
| cfg_offmode | input | 1 | 1 = immediate is the step, 0 = element size is the step |
| cfg_amount | input | 32 | Offset amount added to the start |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_fbank | input | 1 | Bank of the base and data registers |
| cmd_base_reg | input | 5 | Base register number |
| cmd_base_val | input | 32 | Base register contents |
| cmd_imm | input | 32 | Immediate |
| cmd_vreg | input | 5 | First data register N |
| cmd_vlen | input | 6 | Vector length 0..32 |
| cmd_seg | input | 3 | Segment count S (S+1 fields) |
| cmd_esize | input | 2 | Element-size code |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_store | output | 1 | Direction of the request |
| req_fbank | output | 1 | Bank of the register index |
| req_addr | output | 32 | Byte address |
| req_reg | output | 5 | Register index |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | One-cycle refused-command pulse |

## Verification
Two events can meet in one cycle: a setup write to a slot, and acceptance of a command whose base register that same write targets. The bench raises `cfg_valid` and `cmd_valid` on the same edge. It expects the command to walk with the old unit-size step, and an immediately following command to use the new offset step. A second collision is a stall on the final element while done is pending. Here the bench holds `req_ready` low and judges that done comes only in the cycle after the real acceptance.

// File: rtl/vss_pkg.sv
package vss_pkg;
    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int REGW  = $clog2(NREG);
    localparam int VLW   = 6;
    localparam int SEGW  = 3;
    localparam int ESW   = 2;
    localparam int NSLOT = 2;
    localparam int SLOTW = $clog2(NSLOT);
    localparam int CNTW  = VLW + SEGW + 1;
    localparam int RIW   = REGW + VLW + SEGW;

    typedef struct packed {
        logic            vld;
        logic [REGW-1:0] rnum;
        logic            fbank;
        logic            offmode;
        logic [XLEN-1:0] amount;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_ABORT = 2'd3
    } seq_state_t;

    function automatic logic [XLEN-1:0] elem_bytes(input logic [ESW-1:0] code);
        return XLEN'(1) << code;
    endfunction
endpackage

// File: rtl/vss_slot_bank.sv
module vss_slot_bank
    import vss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SLOTW-1:0] wr_sel,
    input  slot_t            wr_data,
    input  logic [REGW-1:0]  look_reg,
    input  logic             look_bank,
    output logic             hit,
    output slot_t            hit_slot
);
    slot_t [NSLOT-1:0] slots;
    logic  [NSLOT-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (wr_sel == SLOTW'(s)) slots[s] <= wr_data;
            end
        end
    end

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_match
            assign match[s] = slots[s].vld && (slots[s].rnum == look_reg)
                              && (slots[s].fbank == look_bank);
        end
    endgenerate

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (match[s]) begin
                hit      = 1'b1;
                hit_slot = slots[s];
            end
        end
    end

    // R1
    slot_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == '0) |=> (slots[0] == $past(wr_data)));
endmodule

// File: rtl/vss_plan.sv
module vss_plan
    import vss_pkg::*;
(
    input  logic            hit,
    input  slot_t           slot,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] imm,
    input  logic [ESW-1:0]  esize,
    output logic [XLEN-1:0] start,
    output logic [XLEN-1:0] stride
);
    logic [XLEN-1:0] bias;

    always_comb begin
        bias   = hit ? slot.amount : '0;
        start  = base_val + bias;
        stride = (hit && slot.offmode) ? imm : elem_bytes(esize);
    end
endmodule

// File: rtl/vss_walker.sv
module vss_walker
    import vss_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            advance,
    input  logic [XLEN-1:0] ld_addr,
    input  logic [XLEN-1:0] ld_stride,
    input  logic [REGW-1:0] ld_reg,
    input  logic [VLW-1:0]  ld_vl,
    input  logic [SEGW-1:0] ld_seg,
    output logic [XLEN-1:0] addr,
    output logic [RIW-1:0]  reg_idx,
    output logic            last
);
    logic [XLEN-1:0] addr_q, stride_q;
    logic [RIW-1:0]  row_q, reg_q;
    logic [VLW-1:0]  vl_q;
    logic [SEGW-1:0] seg_q, j_q;
    logic [CNTW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            stride_q <= '0;
            row_q    <= '0;
            reg_q    <= '0;
            vl_q     <= '0;
            seg_q    <= '0;
            j_q      <= '0;
            rem_q    <= '0;
        end else if (load) begin
            addr_q   <= ld_addr;
            stride_q <= ld_stride;
            row_q    <= RIW'(ld_reg);
            reg_q    <= RIW'(ld_reg);
            vl_q     <= ld_vl;
            seg_q    <= ld_seg;
            j_q      <= '0;
            rem_q    <= CNTW'(ld_vl) * (CNTW'(ld_seg) + CNTW'(1));
        end else if (advance) begin
            addr_q <= addr_q + stride_q;
            rem_q  <= rem_q - CNTW'(1);
            if (j_q == seg_q) begin
                j_q   <= '0;
                row_q <= row_q + RIW'(1);
                reg_q <= row_q + RIW'(1);
            end else begin
                j_q   <= j_q + SEGW'(1);
                reg_q <= reg_q + RIW'(vl_q);
            end
        end
    end

    assign addr    = addr_q;
    assign reg_idx = reg_q;
    assign last    = (rem_q == CNTW'(1));

    // R8
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> ($stable(addr_q) && $stable(reg_q)));
endmodule

// File: rtl/vec_stride_seq.sv
module vec_stride_seq
    import vss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  logic [SLOTW-1:0] cfg_slot,
    input  logic [REGW-1:0]  cfg_reg,
    input  logic             cfg_fbank,
    input  logic             cfg_offmode,
    input  logic [XLEN-1:0]  cfg_amount,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_store,
    input  logic             cmd_fbank,
    input  logic [REGW-1:0]  cmd_base_reg,
    input  logic [XLEN-1:0]  cmd_base_val,
    input  logic [XLEN-1:0]  cmd_imm,
    input  logic [REGW-1:0]  cmd_vreg,
    input  logic [VLW-1:0]   cmd_vlen,
    input  logic [SEGW-1:0]  cmd_seg,
    input  logic [ESW-1:0]   cmd_esize,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_store,
    output logic             req_fbank,
    output logic [XLEN-1:0]  req_addr,
    output logic [REGW-1:0]  req_reg,
    output logic             done,
    output logic             err
);
    seq_state_t      state_q, state_d;
    logic            store_q, fbank_q;
    slot_t           wr_data, hit_slot;
    logic            hit;
    logic [XLEN-1:0] p_start, p_stride;
    logic [CNTW-1:0] total;
    logic [RIW-1:0]  need, reg_wide;
    logic            accept, bad, empty, load, advance, last;

    assign wr_data = '{vld: 1'b1, rnum: cfg_reg, fbank: cfg_fbank,
                       offmode: cfg_offmode, amount: cfg_amount};

    vss_slot_bank u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_valid),
        .wr_sel   (cfg_slot),
        .wr_data  (wr_data),
        .look_reg (cmd_base_reg),
        .look_bank(cmd_fbank),
        .hit      (hit),
        .hit_slot (hit_slot)
    );

    vss_plan u_plan (
        .hit     (hit),
        .slot    (hit_slot),
        .base_val(cmd_base_val),
        .imm     (cmd_imm),
        .esize   (cmd_esize),
        .start   (p_start),
        .stride  (p_stride)
    );

    assign total   = CNTW'(cmd_vlen) * (CNTW'(cmd_seg) + CNTW'(1));
    assign need    = RIW'(cmd_vreg) + RIW'(total);
    assign empty   = (total == '0);
    assign bad     = !empty && (need > RIW'(NREG));
    assign accept  = cmd_valid && (state_q == ST_IDLE);
    assign load    = accept && !bad && !empty;
    assign advance = (state_q == ST_RUN) && req_ready;

    vss_walker u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .ld_addr  (p_start),
        .ld_stride(p_stride),
        .ld_reg   (cmd_vreg),
        .ld_vl    (cmd_vlen),
        .ld_seg   (cmd_seg),
        .addr     (req_addr),
        .reg_idx  (reg_wide),
        .last     (last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (bad)        state_d = ST_ABORT;
                    else if (empty) state_d = ST_DONE;
                    else            state_d = ST_RUN;
                end
            end
            ST_RUN:   if (req_ready && last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            fbank_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                store_q <= cmd_store;
                fbank_q <= cmd_fbank;
            end
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign req_valid = (state_q == ST_RUN);
    assign req_store = store_q;
    assign req_fbank = fbank_q;
    assign req_reg   = reg_wide[REGW-1:0];
    assign done      = (state_q == ST_DONE);
    assign err       = (state_q == ST_ABORT);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg)));

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && cmd_ready));

    // R10
    reg_bound_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (reg_wide < RIW'(NREG)));

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> (!req_valid && !done));

    // R11
    attr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid)) |-> ($stable(req_store) && $stable(req_fbank)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !req_valid);
endmodule

// File: tb/vec_stride_seq_tb.sv
`timescale 1ns/1ps
module vec_stride_seq_tb_top;
    import vss_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_valid = 1'b0;
    logic [SLOTW-1:0] cfg_slot = '0;
    logic [REGW-1:0]  cfg_reg = '0;
    logic             cfg_fbank = 1'b0;
    logic             cfg_offmode = 1'b0;
    logic [XLEN-1:0]  cfg_amount = '0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic             cmd_store = 1'b0;
    logic             cmd_fbank = 1'b0;
    logic [REGW-1:0]  cmd_base_reg = '0;
    logic [XLEN-1:0]  cmd_base_val = '0;
    logic [XLEN-1:0]  cmd_imm = '0;
    logic [REGW-1:0]  cmd_vreg = '0;
    logic [VLW-1:0]   cmd_vlen = '0;
    logic [SEGW-1:0]  cmd_seg = '0;
    logic [ESW-1:0]   cmd_esize = '0;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic             req_store, req_fbank;
    logic [XLEN-1:0]  req_addr;
    logic [REGW-1:0]  req_reg;
    logic             done, err;

    int checks = 0;
    int fails  = 0;
    bit pend_cfg = 1'b0;

    logic        m_vld  [2] = '{1'b0, 1'b0};
    logic [4:0]  m_reg  [2];
    logic        m_bank [2];
    logic        m_mode [2];
    logic [31:0] m_amt  [2];

    always #2 clk = ~clk;

    vec_stride_seq dut_i (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg),
        .cfg_fbank(cfg_fbank), .cfg_offmode(cfg_offmode), .cfg_amount(cfg_amount),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
        .cmd_fbank(cmd_fbank), .cmd_base_reg(cmd_base_reg), .cmd_base_val(cmd_base_val),
        .cmd_imm(cmd_imm), .cmd_vreg(cmd_vreg), .cmd_vlen(cmd_vlen),
        .cmd_seg(cmd_seg), .cmd_esize(cmd_esize),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_fbank(req_fbank), .req_addr(req_addr), .req_reg(req_reg),
        .done(done), .err(err)
    );

    task automatic chk(input bit c, input string tag, input longint act, input longint exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic void plan_exp(input logic [4:0] breg, input logic bank,
                                     input logic [31:0] bval, input logic [31:0] imm,
                                     input logic [1:0] es,
                                     output logic [31:0] st, output logic [31:0] sd);
        bit found = 1'b0;
        st = bval;
        sd = 32'd1 << es;
        for (int s = 0; s < 2; s++) begin
            if (!found && m_vld[s] && m_reg[s] == breg && m_bank[s] == bank) begin
                found = 1'b1;
                st = bval + m_amt[s];
                if (m_mode[s]) sd = imm;
            end
        end
    endfunction

    task automatic cfg_write(input int sl, input logic [4:0] r, input logic b,
                             input logic md, input logic [31:0] amt);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_slot = SLOTW'(sl); cfg_reg = r;
        cfg_fbank = b; cfg_offmode = md; cfg_amount = amt;
        @(negedge clk);
        cfg_valid = 1'b0;
        m_vld[sl] = 1'b1; m_reg[sl] = r; m_bank[sl] = b; m_mode[sl] = md; m_amt[sl] = amt;
    endtask

    task automatic run_cmd(input string tag, input bit store, input bit bank,
                           input logic [4:0] breg, input logic [31:0] bval,
                           input logic [31:0] imm, input logic [4:0] vreg,
                           input int vl, input int seg, input logic [1:0] es,
                           input int rmode, input bit exp_err);
        logic [31:0] est, estr, sa, sr;
        int total, k, cyc;
        bit fin, prev_stall;
        plan_exp(breg, bank, bval, imm, es, est, estr);
        total = vl * (seg + 1);
        @(negedge clk);
        chk(cmd_ready == 1'b1, {tag, " R7 cmd_ready idle"}, cmd_ready, 1);
        cmd_valid = 1'b1; cmd_store = store; cmd_fbank = bank; cmd_base_reg = breg;
        cmd_base_val = bval; cmd_imm = imm; cmd_vreg = vreg;
        cmd_vlen = VLW'(vl); cmd_seg = SEGW'(seg); cmd_esize = es;
        if (pend_cfg) cfg_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cfg_valid = 1'b0; pend_cfg = 1'b0;
        if (exp_err) begin
            chk(err == 1'b1 && req_valid == 1'b0, {tag, " R10 err pulse"}, {err, req_valid}, 2'b10);
            @(negedge clk);
            chk(err == 1'b0 && done == 1'b0 && cmd_ready == 1'b1,
                {tag, " R10 err single, no done"}, {err, done, cmd_ready}, 3'b001);
            return;
        end
        k = 0; cyc = 0; fin = 1'b0; prev_stall = 1'b0; sa = '0; sr = '0;
        while (!fin && cyc < 600) begin
            req_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (done) begin
                chk(k == total, {tag, " R9 done after last accept"}, k, total);
                chk(req_valid == 1'b0 && err == 1'b0, {tag, " R9 done alone"}, {req_valid, err}, 0);
                fin = 1'b1;
            end else if (req_valid) begin
                if (prev_stall)
                    chk(req_addr == sa && 32'(req_reg) == sr, {tag, " R8 stall hold"},
                        {req_addr, 27'(0), req_reg}, {sa, 27'(0), sr[4:0]});
                if (req_ready) begin
                    automatic int i = k / (seg + 1);
                    automatic int j = k % (seg + 1);
                    automatic logic [31:0] ea = est + 32'(k) * estr;
                    automatic int er = int'(vreg) + j * vl + i;
                    chk(k < total, {tag, " R7 request count"}, k, total);
                    chk(req_addr == ea, {tag, " R3/R4/R5/R6 address"}, req_addr, ea);
                    chk(int'(req_reg) == er, {tag, " R5/R6 register"}, req_reg, er);
                    chk(req_store == store && req_fbank == bank, {tag, " R11 attributes"},
                        {req_store, req_fbank}, {store, bank});
                    k++;
                end
                prev_stall = !req_ready;
                sa = req_addr; sr = 32'(req_reg);
            end else begin
                chk(1'b0, {tag, " R8 valid dropped early"}, k, total);
                fin = 1'b1;
            end
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, {tag, " R9 done seen"}, fin, 1);
        @(negedge clk);
        req_ready = 1'b0;
        chk(done == 1'b0 && cmd_ready == 1'b1, {tag, " R9 single done, ready again"},
            {done, cmd_ready}, 2'b01);
    endtask

    task automatic t_reset();
        chk(req_valid == 1'b0 && done == 1'b0 && err == 1'b0, "reset R8 outputs quiet",
            {req_valid, done, err}, 0);
        chk(cmd_ready == 1'b1, "reset R7 cmd_ready", cmd_ready, 1);
    endtask

    task automatic t_unit();
        run_cmd("unit", 1'b0, 1'b0, 5'd5, 32'h1000, 32'd0, 5'd8, 4, 0, 2'd2, 0, 1'b0);
        run_cmd("unit_byte", 1'b0, 1'b0, 5'd3, 32'h2001, 32'd0, 5'd0, 5, 0, 2'd0, 1, 1'b0);
    endtask

    task automatic t_offset();
        cfg_write(0, 5'd5, 1'b0, 1'b1, 32'h20);
        run_cmd("offset R3", 1'b1, 1'b0, 5'd5, 32'h1000, 32'd12, 5'd10, 4, 0, 2'd2, 0, 1'b0);
        run_cmd("offset_neg R3", 1'b0, 1'b0, 5'd5, 32'h8, 32'hFFFF_FFF0, 5'd1, 3, 0, 2'd2, 1, 1'b0);
        run_cmd("bank_miss R2", 1'b1, 1'b1, 5'd5, 32'h4000, 32'd12, 5'd2, 3, 0, 2'd3, 0, 1'b0);
    endtask

    task automatic t_unit_slot();
        cfg_write(1, 5'd7, 1'b1, 1'b0, 32'h100);
        run_cmd("slot_unit R4", 1'b0, 1'b1, 5'd7, 32'h3000, 32'd99, 5'd16, 4, 0, 2'd1, 0, 1'b0);
    endtask

    task automatic t_priority();
        cfg_write(1, 5'd5, 1'b0, 1'b1, 32'h40);
        run_cmd("priority R2", 1'b0, 1'b0, 5'd5, 32'h500, 32'd6, 5'd4, 3, 0, 2'd2, 0, 1'b0);
    endtask

    task automatic t_segment();
        run_cmd("seg R6", 1'b0, 1'b0, 5'd12, 32'h6000, 32'd0, 5'd4, 3, 2, 2'd2, 1, 1'b0);
        run_cmd("seg_edge R10", 1'b1, 1'b0, 5'd12, 32'h7000, 32'd0, 5'd20, 6, 1, 2'd3, 0, 1'b0);
    endtask

    task automatic t_zero_and_error();
        run_cmd("zero R7", 1'b0, 1'b0, 5'd1, 32'h0, 32'd0, 5'd3, 0, 0, 2'd2, 0, 1'b0);
        run_cmd("over R10", 1'b0, 1'b0, 5'd1, 32'h0, 32'd0, 5'd30, 3, 0, 2'd2, 0, 1'b1);
        run_cmd("seg_over R10", 1'b0, 1'b0, 5'd1, 32'h0, 32'd0, 5'd20, 7, 1, 2'd2, 0, 1'b1);
        run_cmd("after_err R10", 1'b0, 1'b0, 5'd1, 32'h0, 32'd0, 5'd29, 3, 0, 2'd2, 0, 1'b0);
    endtask

    task automatic t_same_cycle();
        cfg_slot = '0; cfg_reg = 5'd9; cfg_fbank = 1'b0; cfg_offmode = 1'b1; cfg_amount = 32'h8;
        pend_cfg = 1'b1;
        run_cmd("same_cycle_old R1", 1'b0, 1'b0, 5'd9, 32'h9000, 32'd20, 5'd6, 3, 0, 2'd2, 0, 1'b0);
        m_vld[0] = 1'b1; m_reg[0] = 5'd9; m_bank[0] = 1'b0; m_mode[0] = 1'b1; m_amt[0] = 32'h8;
        run_cmd("same_cycle_new R1", 1'b0, 1'b0, 5'd9, 32'h9000, 32'd20, 5'd6, 3, 0, 2'd2, 0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit();
        t_offset();
        t_unit_slot();
        t_priority();
        t_segment();
        t_zero_and_error();
        t_same_cycle();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule